// File: doc/BRIEF.md
# Staged Processor Reset Release Sequencer

This block owns three active-low reset lines of an attached processor and lets them go one after another: first the general system reset, then the power-on reset, then the full reset. Each gap between releases is a fixed count of system-clock cycles set by a parameter. A sequence starts on power-up once the power-good and clock-valid inputs have both been high for a minimum hold time. It also starts when the host pulses a soft-reset request. A soft-reset request takes effect at any point in a running sequence: it pulls all three lines low again and restarts from the hold phase.

The boot-configuration value is driven onto a dedicated output bus inside a window that surrounds the full-reset release edge. The window opens a set number of cycles before that edge and closes a set number of cycles after it, so the processor can latch the value on the rising edge of its full reset. Once the full reset is released, the block watches the processor's active-low reset-status output. It raises a one-cycle done pulse when the processor leaves reset. If the processor stays in reset too long, it sets a sticky timeout flag. A loss of power-good at any time pulls every line low at once and holds them low.

Top module: `rst_release_seq`

## Requirements
- R1: While `rst` is high, and while `pwr_good_i` and `clk_ok_i` are not both high, the three reset outputs, `cfg_oe_o`, `seq_done_o` and `seq_timeout_o` read 0. Power-up release of `sys_rst_n_o` happens at the HOLD_MIN_CYC-th consecutive rising edge on which both inputs are sampled high.
- R2: `por_rst_n_o` rises exactly POR_GAP_CYC cycles after `sys_rst_n_o` rises, and never before it.
- R3: `full_rst_n_o` rises exactly FULL_GAP_CYC cycles after `por_rst_n_o` rises.
- R4: `cfg_oe_o` rises CFG_SETUP_CYC cycles before `full_rst_n_o` rises and falls CFG_HOLD_CYC cycles after it. `cfg_val_o` equals BOOT_CFG while `cfg_oe_o` is 1 and is all-zero otherwise.
- R5: A soft-reset request sampled high on an edge drives all three reset outputs low after that edge, and the hold phase restarts from zero. `sys_rst_n_o` rises HOLD_MIN_CYC+1 cycles after the edge on which the request was driven, measured from the preceding falling edge.
- R6: `pwr_good_i` sampled low drives all three resets and `cfg_oe_o` low after that edge. They stay low while `pwr_good_i` stays low, even if a soft-reset request is made.
- R7: `tgt_rst_stat_n_i` (1 = processor out of reset) is sampled on each edge from the first edge after `full_rst_n_o` rises. If it is sampled 1 on the d-th such edge with d ≤ STAT_TIMEOUT_CYC, `seq_done_o` is high for exactly the one cycle after that edge.
- R8: If STAT_TIMEOUT_CYC such samples are all 0, `seq_timeout_o` is set after the last of them and no done pulse follows. It stays set until the next sequence releases `sys_rst_n_o`, and it reads 0 from that cycle.
- R9: A soft-reset request or power-good loss on the same edge that samples `tgt_rst_stat_n_i` high gives no done pulse. The sequence restarts instead.
- R10: After a sequence completes, all three resets stay released and no further done pulse appears until a new sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_good_i | input | 1 | Supply rails stable |
| clk_ok_i | input | 1 | Processor clocks running |
| soft_rst_req_i | input | 1 | Host soft-reset request, sampled each edge |
| tgt_rst_stat_n_i | input | 1 | Processor reset status, 0 while in reset |
| sys_rst_n_o | output | 1 | General system reset, active low, released first |
| por_rst_n_o | output | 1 | Power-on reset, active low, released second |
| full_rst_n_o | output | 1 | Full reset, active low, released last |
| cfg_oe_o | output | 1 | Boot-configuration drive enable |
| cfg_val_o | output | CFG_W | Boot-configuration value, zero outside the window |
| seq_done_o | output | 1 | One-cycle pulse when the processor leaves reset |
| seq_timeout_o | output | 1 | Sticky flag: processor did not leave reset in time |

## Verification
The sharpest collision comes when a soft-reset request arrives on the same edge that first samples the processor's reset status as inactive. Completion and restart then compete for one cycle. The bench lets a sequence reach the monitoring phase, then raises the status input and the request on the same falling edge. It expects the resets low and no done pulse after the next rising edge. A second collision, power loss together with a soft request, is judged by the lines staying low for as long as power-good stays low.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // Phases of one release sequence, in the order they run.
    typedef enum logic [2:0] {
        SEQ_HOLD    = 3'd0,   // every line asserted, waiting for supplies
        SEQ_SYS_UP  = 3'd1,   // general reset released
        SEQ_POR_UP  = 3'd2,   // power-on reset released as well
        SEQ_CFG_WIN = 3'd3,   // full reset released, config still driven
        SEQ_RUN     = 3'd4    // everything released, config withdrawn
    } seq_state_e;

    // The registered output lines travel together as one struct.
    typedef struct packed {
        logic sys_n;
        logic por_n;
        logic full_n;
        logic cfg_oe;
    } rst_lines_t;

    localparam rst_lines_t LINES_ASSERTED = '0;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Line levels for a phase; cfg_early opens the window ahead of full release.
    function automatic rst_lines_t lines_for(input seq_state_e st, input logic cfg_early);
        rst_lines_t l;
        l = LINES_ASSERTED;
        unique case (st)
            SEQ_HOLD:    l = LINES_ASSERTED;
            SEQ_SYS_UP:  l.sys_n = 1'b1;
            SEQ_POR_UP: begin
                l.sys_n  = 1'b1;
                l.por_n  = 1'b1;
                l.cfg_oe = cfg_early;
            end
            SEQ_CFG_WIN: begin
                l.sys_n  = 1'b1;
                l.por_n  = 1'b1;
                l.full_n = 1'b1;
                l.cfg_oe = 1'b1;
            end
            SEQ_RUN: begin
                l.sys_n  = 1'b1;
                l.por_n  = 1'b1;
                l.full_n = 1'b1;
            end
            default: l = LINES_ASSERTED;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned HOLD_MIN_CYC  = 16,
    parameter int unsigned POR_GAP_CYC   = 200000,
    parameter int unsigned FULL_GAP_CYC  = 10000,
    parameter int unsigned CFG_SETUP_CYC = 100,
    parameter int unsigned CFG_HOLD_CYC  = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good_i,
    input  logic       clk_ok_i,
    input  logic       soft_req_i,
    output rst_lines_t lines_o,
    output logic       arm_o,     // high in the first cycle full reset reads released
    output logic       start_o,   // high in the cycle the hold phase ends
    output logic       kill_o     // restart condition seen this cycle
);

    localparam int unsigned LONGEST = max4(HOLD_MIN_CYC, POR_GAP_CYC, FULL_GAP_CYC, CFG_HOLD_CYC);
    localparam int          CNT_W   = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] FULL_LAST  = CNT_W'(FULL_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] CHOLD_LAST = CNT_W'(CFG_HOLD_CYC - 1);
    // Count value inside the power-on phase at which the config window opens.
    localparam logic [CNT_W-1:0] CFG_FROM   = CNT_W'(FULL_GAP_CYC - CFG_SETUP_CYC);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    rst_lines_t       lines_q;
    logic             arm_q;
    logic             supply_ok;
    logic             kill;
    logic             cfg_early;

    assign supply_ok = pwr_good_i && clk_ok_i;
    assign kill      = !pwr_good_i || soft_req_i;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + 1'b1;
        if (kill) begin
            st_d  = SEQ_HOLD;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                SEQ_HOLD: begin
                    if (!supply_ok) begin
                        cnt_d = '0;
                    end else if (cnt_q == HOLD_LAST) begin
                        st_d  = SEQ_SYS_UP;
                        cnt_d = '0;
                    end
                end
                SEQ_SYS_UP: begin
                    if (cnt_q == POR_LAST) begin
                        st_d  = SEQ_POR_UP;
                        cnt_d = '0;
                    end
                end
                SEQ_POR_UP: begin
                    if (cnt_q == FULL_LAST) begin
                        st_d  = SEQ_CFG_WIN;
                        cnt_d = '0;
                    end
                end
                SEQ_CFG_WIN: begin
                    if (cnt_q == CHOLD_LAST) begin
                        st_d  = SEQ_RUN;
                        cnt_d = '0;
                    end
                end
                SEQ_RUN: cnt_d = cnt_q;
                default: begin
                    st_d  = SEQ_HOLD;
                    cnt_d = '0;
                end
            endcase
        end
    end

    assign cfg_early = (st_d == SEQ_POR_UP) && (cnt_d >= CFG_FROM);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_HOLD;
            cnt_q   <= '0;
            lines_q <= LINES_ASSERTED;
            arm_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            lines_q <= lines_for(st_d, cfg_early);
            arm_q   <= (st_q == SEQ_POR_UP) && (st_d == SEQ_CFG_WIN);
        end
    end

    assign lines_o = lines_q;
    assign arm_o   = arm_q;
    assign start_o = (st_q == SEQ_HOLD) && (st_d == SEQ_SYS_UP);
    assign kill_o  = kill;

    AST_UNQUALIFIED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clk_ok_i && !lines_q.sys_n) |=> !lines_q.sys_n); // R1
    AST_SYS_BEFORE_POR: assert property (@(posedge clk) disable iff (rst)
        $rose(lines_q.por_n) |-> $past(lines_q.sys_n)); // R2
    AST_POR_BEFORE_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(lines_q.full_n) |-> $past(lines_q.por_n)); // R3
    AST_CFG_INSIDE_WIN: assert property (@(posedge clk) disable iff (rst)
        lines_q.cfg_oe |-> (lines_q.por_n && lines_q.sys_n)); // R4
    AST_SOFT_REASSERT: assert property (@(posedge clk) disable iff (rst)
        soft_req_i |=> (!lines_q.sys_n && !lines_q.por_n && !lines_q.full_n)); // R5
    AST_PWR_LOSS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pwr_good_i |=> (lines_q == LINES_ASSERTED)); // R6

endmodule

// File: rtl/rst_stat_monitor.sv
module rst_stat_monitor #(
    parameter int unsigned TIMEOUT_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,      // first cycle with full reset released
    input  logic abort_i,    // sequence is being restarted
    input  logic clear_i,    // new sequence leaves its hold phase
    input  logic stat_n_i,   // 1 = processor out of reset
    output logic done_o,
    output logic timeout_o
);

    localparam int               TO_W    = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0]  TO_LAST = TO_W'(TIMEOUT_CYC - 1);

    logic            watch_q;
    logic [TO_W-1:0] tcnt_q;
    logic            done_q;
    logic            err_q;
    logic            active;
    logic [TO_W-1:0] tsel;

    assign active = watch_q || arm_i;
    assign tsel   = arm_i ? '0 : tcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            watch_q <= 1'b0;
            tcnt_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clear_i) err_q <= 1'b0;
            if (abort_i) begin
                watch_q <= 1'b0;
            end else if (active) begin
                if (stat_n_i) begin
                    done_q  <= 1'b1;
                    watch_q <= 1'b0;
                end else if (tsel == TO_LAST) begin
                    err_q   <= 1'b1;
                    watch_q <= 1'b0;
                end else begin
                    tcnt_q  <= tsel + 1'b1;
                    watch_q <= 1'b1;
                end
            end
        end
    end

    assign done_o    = done_q;
    assign timeout_o = err_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clear_i) |=> err_q); // R8
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !done_q); // R9

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
    import rst_seq_pkg::*;
#(
    parameter int unsigned HOLD_MIN_CYC     = 16,
    parameter int unsigned POR_GAP_CYC      = 200000,
    parameter int unsigned FULL_GAP_CYC     = 10000,
    parameter int unsigned CFG_SETUP_CYC    = 100,
    parameter int unsigned CFG_HOLD_CYC     = 10000,
    parameter int unsigned STAT_TIMEOUT_CYC = 1000000,
    parameter int unsigned CFG_W            = 8,
    parameter logic [CFG_W-1:0] BOOT_CFG    = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good_i,
    input  logic             clk_ok_i,
    input  logic             soft_rst_req_i,
    input  logic             tgt_rst_stat_n_i,
    output logic             sys_rst_n_o,
    output logic             por_rst_n_o,
    output logic             full_rst_n_o,
    output logic             cfg_oe_o,
    output logic [CFG_W-1:0] cfg_val_o,
    output logic             seq_done_o,
    output logic             seq_timeout_o
);

    rst_lines_t lines;
    logic       arm;
    logic       start;
    logic       kill;

    rst_seq_fsm #(
        .HOLD_MIN_CYC  (HOLD_MIN_CYC),
        .POR_GAP_CYC   (POR_GAP_CYC),
        .FULL_GAP_CYC  (FULL_GAP_CYC),
        .CFG_SETUP_CYC (CFG_SETUP_CYC),
        .CFG_HOLD_CYC  (CFG_HOLD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_good_i (pwr_good_i),
        .clk_ok_i   (clk_ok_i),
        .soft_req_i (soft_rst_req_i),
        .lines_o    (lines),
        .arm_o      (arm),
        .start_o    (start),
        .kill_o     (kill)
    );

    rst_stat_monitor #(
        .TIMEOUT_CYC (STAT_TIMEOUT_CYC)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm),
        .abort_i   (kill),
        .clear_i   (start),
        .stat_n_i  (tgt_rst_stat_n_i),
        .done_o    (seq_done_o),
        .timeout_o (seq_timeout_o)
    );

    assign sys_rst_n_o  = lines.sys_n;
    assign por_rst_n_o  = lines.por_n;
    assign full_rst_n_o = lines.full_n;
    assign cfg_oe_o     = lines.cfg_oe;
    assign cfg_val_o    = lines.cfg_oe ? BOOT_CFG : '0;

    AST_DONE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        seq_done_o |-> (full_rst_n_o && por_rst_n_o && sys_rst_n_o)); // R10

endmodule

// File: tb/rst_release_seq_bench.sv
module rst_release_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 4;
    localparam int POR   = 20;
    localparam int FULL  = 10;
    localparam int SETUP = 3;
    localparam int CHOLD = 6;
    localparam int TO    = 15;
    localparam logic [7:0] BOOT = 8'h5A;
    localparam int WATCHDOG = 20000;

    // Vector: {status delay after full release [8:1], done expected [0]}; delay 0 = already high.
    localparam int NVEC = 5;
    localparam logic [8:0] VECS [NVEC] = '{
        {8'd0,  1'b1},
        {8'd1,  1'b1},
        {8'd6,  1'b1},
        {8'd15, 1'b1},
        {8'd16, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b0;
    logic       clk_ok = 1'b0;
    logic       soft_req = 1'b0;
    logic       stat_n = 1'b0;
    logic       sys_n, por_n, full_n, cfg_oe, seq_done, seq_timeout;
    logic [7:0] cfg_val;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    rst_release_seq #(
        .HOLD_MIN_CYC(HOLD), .POR_GAP_CYC(POR), .FULL_GAP_CYC(FULL),
        .CFG_SETUP_CYC(SETUP), .CFG_HOLD_CYC(CHOLD), .STAT_TIMEOUT_CYC(TO),
        .CFG_W(8), .BOOT_CFG(BOOT)
    ) u_rst_release_seq (
        .clk(clk), .rst(rst), .pwr_good_i(pwr_good), .clk_ok_i(clk_ok),
        .soft_rst_req_i(soft_req), .tgt_rst_stat_n_i(stat_n),
        .sys_rst_n_o(sys_n), .por_rst_n_o(por_n), .full_rst_n_o(full_n),
        .cfg_oe_o(cfg_oe), .cfg_val_o(cfg_val),
        .seq_done_o(seq_done), .seq_timeout_o(seq_timeout)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int lines3();
        return {29'd0, sys_n, por_n, full_n};
    endfunction

    task automatic pulse_soft();
        soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0;
    endtask

    task automatic run_seq(input int dly, input bit exp_done, input bit by_soft);
        int t_ref;
        int t_sys = -1, t_por = -1, t_full = -1, t_con = -1, t_coff = -1, t_end = -1;
        bit err_before;
        bit saw_done = 0, saw_err = 0, prev_done = 0, wide = 0, bad_cfg = 0;
        err_before = seq_timeout;
        stat_n = (dly == 0);
        if (by_soft) soft_req = 1'b1;
        else begin pwr_good = 1'b1; clk_ok = 1'b1; end
        t_ref = cyc;
        @(negedge clk);
        soft_req = 1'b0;
        chk(by_soft ? "R5 lines low after request" : "R1 lines low at qualify", lines3(), 0);
        chk("R8 flag held until release", int'(seq_timeout), int'(err_before));
        for (int i = 0; i < 2000 && (t_end < 0 || t_coff < 0); i++) begin
            if (t_sys < 0 && sys_n) begin
                t_sys = cyc;
                chk("R8 flag cleared at release", int'(seq_timeout), 0);
            end
            if (t_por < 0 && por_n) t_por = cyc;
            if (t_full < 0 && full_n) t_full = cyc;
            if (cfg_oe && t_con < 0) t_con = cyc;
            if (!cfg_oe && t_con >= 0 && t_coff < 0) t_coff = cyc;
            if (cfg_oe && cfg_val != BOOT) bad_cfg = 1;
            if (!cfg_oe && cfg_val != 8'd0) bad_cfg = 1;
            if (prev_done && seq_done) wide = 1;
            if (seq_done) begin saw_done = 1; if (t_end < 0) t_end = cyc; end
            if (t_full >= 0 && seq_timeout && t_end < 0) begin saw_err = 1; t_end = cyc; end
            prev_done = seq_done;
            if (t_full >= 0 && dly > 0 && cyc == t_full + dly - 1) stat_n = 1'b1;
            @(negedge clk);
        end
        chk(by_soft ? "R5 restart hold length" : "R1 power-up hold length",
            t_sys - t_ref, by_soft ? HOLD + 1 : HOLD);
        chk("R2 por gap", t_por - t_sys, POR);
        chk("R3 full gap", t_full - t_por, FULL);
        chk("R4 cfg setup", t_full - t_con, SETUP);
        chk("R4 cfg hold", t_coff - t_full, CHOLD);
        chk("R4 cfg value", int'(bad_cfg), 0);
        if (exp_done) begin
            chk("R7 done seen", int'(saw_done), 1);
            chk("R7 done delay", t_end - t_full, (dly == 0) ? 1 : dly);
            chk("R7 done one cycle", int'(wide), 0);
        end else begin
            chk("R8 timeout seen", int'(saw_err), 1);
            chk("R8 timeout delay", t_end - t_full, TO);
            chk("R8 no done on timeout", int'(saw_done), 0);
        end
        stat_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10 lines stay released", lines3(), 7);
            chk("R10 no extra done", int'(seq_done), 0);
            chk("R8 flag sticky", int'(seq_timeout), exp_done ? 0 : 1);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual %0d expected < %0d cycles", cyc, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset lines", lines3(), 0);
        chk("R1 reset cfg_oe", int'(cfg_oe), 0);
        chk("R1 reset done", int'(seq_done), 0);
        chk("R1 reset timeout", int'(seq_timeout), 0);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 no supply", lines3(), 0);
        end
        pwr_good = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 clocks not valid", lines3(), 0);
        end
        run_seq(0, 1'b1, 1'b0);

        // Vector table walk, ending with a timeout.
        for (int v = 0; v < NVEC; v++)
            run_seq(int'(VECS[v][8:1]), VECS[v][0], 1'b1);

        // R8: sticky flag cleared by the next release.
        run_seq(2, 1'b1, 1'b1);

        // R5: request in the middle of the por gap.
        pulse_soft();
        repeat (8) @(negedge clk);
        chk("R5 mid-sequence sys released", int'(sys_n), 1);
        run_seq(4, 1'b1, 1'b1);

        // R9: request and status on the same edge.
        stat_n = 1'b0;
        pulse_soft();
        for (int i = 0; i < 200 && !full_n; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        stat_n = 1'b1;
        soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0;
        chk("R9 no done on restart", int'(seq_done), 0);
        chk("R9 lines reasserted", lines3(), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 still no done", int'(seq_done), 0);
        end
        chk("R9 no timeout", int'(seq_timeout), 0);

        // R6: power loss during full gap, then request while power is low.
        for (int i = 0; i < 200 && !por_n; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R6 lines low on power loss", lines3(), 0);
        chk("R6 cfg off on power loss", int'(cfg_oe), 0);
        pulse_soft();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R6 held while power low", lines3(), 0);
        end
        run_seq(1, 1'b1, 1'b0);

        // R4/R6: power loss inside the config window, then clocks invalid.
        pulse_soft();
        for (int i = 0; i < 200 && !cfg_oe; i++) @(negedge clk);
        chk("R4 window reached", int'(cfg_oe), 1);
        pwr_good = 1'b0;
        clk_ok = 1'b0;
        @(negedge clk);
        chk("R4 cfg_oe dropped", int'(cfg_oe), 0);
        chk("R4 cfg_val zero", int'(cfg_val), 0);
        pwr_good = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 clock loss blocks release", lines3(), 0);
        end
        run_seq(0, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule